// File: doc/BRIEF.md
# Consumer-Electronics Control Bus Frame Transmitter

This block sends frames on a single-wire, open-drain control bus shared by several consumer devices. The line idles high. Any device may pull it low. The block drives it only through `cec_drive_low` and watches the real level on `cec_in`. It keeps checking whether the bus has been quiet. Once transmission is enabled and the line has stayed high for a programmable number of bit periods, it sends a start bit. It then sends one block after another. Each block holds a data byte, an end-of-message flag and an acknowledge slot.

Software loads one byte and its end-of-message flag into a single-entry buffer. The block takes that entry when the byte's first bit begins. It then pulses `irq_byte`, which tells software to load the next byte. After the block whose end-of-message flag is 1 completes, including its acknowledge check, the block pulses `irq_end` and drops its enable.

A missing acknowledge stops the transfer at once. So does a foreign low level on a released bit, or an empty buffer at a block boundary. In each case the block releases the line, pulses `irq_err` and reports a cause code. While a frame is in progress, `rx_hold` tells the receiver to stay idle.

Bit timing counts a prescaled tick of 50 us:

| Element | Ticks |
|---|---|
| Start bit low | 74 |
| Start bit total | 90 |
| Logic 0 low | 30 |
| Logic 1 low | 12 |
| Bit period | 48 |
| Line sample | 21 |

Top module: `cec_tx`

## Requirements
- R1: A start bit begins only after `cec_in` has been high for `free_periods` x 48 ticks. Bus monitoring runs continuously. If the bus is already free, the start bit begins within one tick of `tx_start`.
- R2: The start bit drives the line low for 74 ticks. The first data bit falls 90 ticks after the start bit fell.
- R3: Every bit period is 48 ticks, falling edge to falling edge. A logic 0 is low for 30 ticks and a logic 1 is low for 12 ticks.
- R4: Each block sends 8 data bits with the most significant bit first. It then sends the end-of-message bit, then an acknowledge slot in which the block drives a logic-1 pulse.
- R5: When the first bit of a block begins, the block takes the buffer entry and `buf_full` goes low. In the same cycle it pulses `irq_byte` for one cycle and sets the sticky flag `stat_byte`.
- R6: Blocks follow one another with no gap until a block whose end-of-message bit is 1 has been sent.
- R7: After the final block's acknowledge check passes, the block pulses `irq_end`, sets `stat_end` and clears `tx_enabled`. Each sticky flag stays set until `stat_clr` is asserted.
- R8: In a directed frame (`broadcast`=0), a high line at the acknowledge sample is an error. The block aborts, releases the line, clears `tx_enabled`, pulses `irq_err`, sets `stat_err` and reports `err_code`=2.
- R9: A low line at the sample point of a data or end-of-message bit that the block sends as 1 aborts the frame with `err_code`=3 and `irq_err`. No further falling edge follows.
- R10: If the buffer is empty when a block's first bit is due, the frame aborts with `err_code`=1 and `irq_err`, and the line stays released. This applies after the start bit and at every later block boundary.
- R11: `rx_hold` is high from the start bit until the frame ends or aborts, and low otherwise.
- R12: In a broadcast frame (`broadcast`=1), a high acknowledge sample is accepted. A low acknowledge sample aborts the frame with `err_code`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Pulse that sets the transmit enable |
| free_periods | input | FREE_W | Number of quiet bit periods required before the start bit |
| broadcast | input | 1 | 1 selects broadcast acknowledge polarity |
| buf_wr | input | 1 | Writes the buffer; ignored while it is full |
| buf_data | input | 8 | Byte to send |
| buf_eom | input | 1 | End-of-message flag for that byte |
| buf_full | output | 1 | Buffer holds an entry that has not been taken |
| stat_clr | input | 1 | Clears all sticky flags |
| cec_in | input | 1 | Observed bus level |
| cec_drive_low | output | 1 | 1 pulls the bus low |
| tx_enabled | output | 1 | Transmit enable; clears itself at end or error |
| rx_hold | output | 1 | Reception held off during a frame |
| irq_byte | output | 1 | One-cycle pulse when a byte is taken |
| irq_end | output | 1 | One-cycle pulse at the end of a frame |
| irq_err | output | 1 | One-cycle pulse on abort |
| err_code | output | 2 | Cause of the last abort: 0 none, 1 underrun, 2 acknowledge, 3 collision |
| stat_byte | output | 1 | Sticky byte-taken flag |
| stat_end | output | 1 | Sticky end flag |
| stat_err | output | 1 | Sticky error flag |

## Verification
The hardest situations to reach are a foreign device pulling the line at one particular bit, and a buffer that runs dry exactly at a block boundary. The bench handles the first with a bus-partner model. The model counts the block's own falling edges to find the bit position, then holds the line low through the acknowledge slot or through a chosen bit. The bench handles the second by withholding a refill after `irq_byte`, or by starting with an empty buffer. It also holds the bus low before a start request and checks the resulting start delay, because bus-free monitoring runs continuously.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  localparam int TCNT_W = 7;
  localparam int BIT_TICKS = 48;
  localparam logic [TCNT_W-1:0] T_START_LOW = 7'd74;
  localparam logic [TCNT_W-1:0] T_START_END = 7'd89;
  localparam logic [TCNT_W-1:0] T_ZERO_LOW  = 7'd30;
  localparam logic [TCNT_W-1:0] T_ONE_LOW   = 7'd12;
  localparam logic [TCNT_W-1:0] T_SAMPLE    = 7'd21;
  localparam logic [TCNT_W-1:0] T_BIT_END   = 7'd47;
  localparam logic [3:0] IDX_EOM = 4'd8;
  localparam logic [3:0] IDX_ACK = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT} tx_state_e;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_UNDERRUN = 2'd1, ERR_NACK = 2'd2, ERR_COLLIDE = 2'd3
  } tx_err_e;
endpackage

// File: rtl/cec_tx_tick.sv
module cec_tx_tick #(
  parameter int CLKS_PER_TICK = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == W'(CLKS_PER_TICK - 1));
    cnt_d = tick ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cec_tx_busfree.sv
module cec_tx_busfree
  import cec_tx_pkg::*;
#(
  parameter int FREE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_raw,
  input  logic [FREE_W-1:0] free_periods,
  output logic              line_s,
  output logic              bus_free
);
  localparam int MAX_TICKS = ((1 << FREE_W) - 1) * BIT_TICKS;
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] idle_q, idle_d;
  logic [CNT_W-1:0] need;

  assign line_s = sync_q[1];

  always_comb begin
    need = CNT_W'(free_periods) * CNT_W'(BIT_TICKS);
    if (!line_s)                                   idle_d = '0;
    else if (tick && idle_q != CNT_W'(MAX_TICKS))  idle_d = idle_q + CNT_W'(1);
    else                                           idle_d = idle_q;
    bus_free = line_s && (idle_q >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      idle_q <= '0;
    end else begin
      sync_q <= {sync_q[0], line_raw};
      idle_q <= idle_d;
    end
  end
endmodule

// File: rtl/cec_tx_buf.sv
module cec_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              weom,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] rdata,
  output logic              reom
);
  logic              full_d;
  logic [DATA_W-1:0] data_d;
  logic              eom_d;
  logic              accept;

  always_comb begin
    accept = wr && !full;
    full_d = accept ? 1'b1 : (take ? 1'b0 : full);
    data_d = accept ? wdata : rdata;
    eom_d  = accept ? weom  : reom;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      rdata <= '0;
      reom  <= 1'b0;
    end else begin
      full  <= full_d;
      rdata <= data_d;
      reom  <= eom_d;
    end
  end
endmodule

// File: rtl/cec_tx.sv
module cec_tx
  import cec_tx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 2,
  parameter int FREE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [FREE_W-1:0] free_periods,
  input  logic              broadcast,
  input  logic              buf_wr,
  input  logic [7:0]        buf_data,
  input  logic              buf_eom,
  output logic              buf_full,
  input  logic              stat_clr,
  input  logic              cec_in,
  output logic              cec_drive_low,
  output logic              tx_enabled,
  output logic              rx_hold,
  output logic              irq_byte,
  output logic              irq_end,
  output logic              irq_err,
  output logic [1:0]        err_code,
  output logic              stat_byte,
  output logic              stat_end,
  output logic              stat_err
);
  logic tick, line_s, bus_free, take;
  logic [7:0] b_data;
  logic b_eom;

  cec_tx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  cec_tx_busfree #(.FREE_W(FREE_W)) u_free (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_raw(cec_in),
    .free_periods(free_periods), .line_s(line_s), .bus_free(bus_free));

  cec_tx_buf #(.DATA_W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(buf_wr), .wdata(buf_data), .weom(buf_eom),
    .take(take), .full(buf_full), .rdata(b_data), .reom(b_eom));

  tx_state_e state_q, state_d;
  logic en_q, en_d;
  logic [TCNT_W-1:0] t_q, t_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] shf_q, shf_d;
  logic eom_q, eom_d;
  tx_err_e err_q, err_d, abort_code;
  logic irqb_q, irqb_d, irqe_q, irqe_d, irqx_q, irqx_d;
  logic sb_q, sb_d, se_q, se_d, sx_q, sx_d;
  logic is_ack, is_eom_bit, cur_bit, load_req, abort;

  always_comb begin
    is_ack     = (bit_q == IDX_ACK);
    is_eom_bit = (bit_q == IDX_EOM);
    cur_bit    = is_ack ? 1'b1 : (is_eom_bit ? eom_q : shf_q[7]);
    cec_drive_low = ((state_q == ST_START) && (t_q < T_START_LOW)) ||
                    ((state_q == ST_BIT) && (t_q < (cur_bit ? T_ONE_LOW : T_ZERO_LOW)));
  end

  always_comb begin
    state_d = state_q; en_d = en_q; t_d = t_q; bit_d = bit_q;
    shf_d = shf_q; eom_d = eom_q; err_d = err_q;
    take = 1'b0; irqb_d = 1'b0; irqe_d = 1'b0; irqx_d = 1'b0;
    load_req = 1'b0; abort = 1'b0; abort_code = ERR_NONE;
    if (tx_start) en_d = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (en_q && bus_free && tick) begin
          state_d = ST_START;
          t_d     = '0;
          err_d   = ERR_NONE;
        end
      end
      ST_START: begin
        if (tick) begin
          if (t_q == T_START_END) load_req = 1'b1;
          else                    t_d = t_q + TCNT_W'(1);
        end
      end
      ST_BIT: begin
        if (tick) begin
          t_d = t_q + TCNT_W'(1);
          if (t_q == T_SAMPLE) begin
            if (is_ack) begin
              if (broadcast ? !line_s : line_s) begin
                abort = 1'b1; abort_code = ERR_NACK;
              end
            end else if (cur_bit && !line_s) begin
              abort = 1'b1; abort_code = ERR_COLLIDE;
            end
          end
          if (t_q == T_BIT_END) begin
            t_d = '0;
            if (is_ack) begin
              if (eom_q) begin
                state_d = ST_IDLE; en_d = 1'b0; irqe_d = 1'b1;
              end else begin
                load_req = 1'b1;
              end
            end else begin
              bit_d = bit_q + 4'd1;
              if (!is_eom_bit) shf_d = {shf_q[6:0], 1'b0};
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load_req) begin
      if (buf_full) begin
        take = 1'b1; shf_d = b_data; eom_d = b_eom; irqb_d = 1'b1;
        state_d = ST_BIT; bit_d = '0; t_d = '0;
      end else begin
        abort = 1'b1; abort_code = ERR_UNDERRUN;
      end
    end
    if (abort) begin
      state_d = ST_IDLE; en_d = 1'b0; irqx_d = 1'b1; err_d = abort_code;
    end
    sb_d = irqb_d | (sb_q & ~stat_clr);
    se_d = irqe_d | (se_q & ~stat_clr);
    sx_d = irqx_d | (sx_q & ~stat_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; en_q <= 1'b0; t_q <= '0; bit_q <= '0;
      shf_q <= '0; eom_q <= 1'b0; err_q <= ERR_NONE;
      irqb_q <= 1'b0; irqe_q <= 1'b0; irqx_q <= 1'b0;
      sb_q <= 1'b0; se_q <= 1'b0; sx_q <= 1'b0;
    end else begin
      state_q <= state_d; en_q <= en_d; t_q <= t_d; bit_q <= bit_d;
      shf_q <= shf_d; eom_q <= eom_d; err_q <= err_d;
      irqb_q <= irqb_d; irqe_q <= irqe_d; irqx_q <= irqx_d;
      sb_q <= sb_d; se_q <= se_d; sx_q <= sx_d;
    end
  end

  assign tx_enabled = en_q;
  assign rx_hold    = (state_q != ST_IDLE);
  assign irq_byte   = irqb_q;
  assign irq_end    = irqe_q;
  assign irq_err    = irqx_q;
  assign err_code   = err_q;
  assign stat_byte  = sb_q;
  assign stat_end   = se_q;
  assign stat_err   = sx_q;
endmodule

// File: rtl/cec_tx_chk.sv
module cec_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       buf_full,
  input logic       cec_drive_low,
  input logic       tx_enabled,
  input logic       rx_hold,
  input logic       irq_byte,
  input logic       irq_end,
  input logic       irq_err,
  input logic [1:0] err_code,
  input logic       stat_byte
);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_hold) |-> cec_drive_low);
  a_r5_byte_frees: assert property (@(posedge clk) disable iff (!rst_n)
    irq_byte |-> !buf_full);
  a_r5_stat_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_byte |-> stat_byte);
  a_r7_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> (!tx_enabled && !rx_hold));
  a_r8_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (!tx_enabled && !cec_drive_low && err_code != 2'd0));
  a_r8_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_byte, irq_end, irq_err}));
  a_r11_hold_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    irq_byte |-> rx_hold);
endmodule

bind cec_tx cec_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .cec_drive_low(cec_drive_low),
  .tx_enabled(tx_enabled), .rx_hold(rx_hold), .irq_byte(irq_byte),
  .irq_end(irq_end), .irq_err(irq_err), .err_code(err_code), .stat_byte(stat_byte));

// File: tb/tb_cec_tx.sv
`timescale 1ns/1ps
module tb_cec_tx;
  localparam int CPT = 2;
  localparam int BITC = 48 * CPT;

  logic clk, rst_n, tx_start, broadcast, buf_wr, buf_eom, stat_clr;
  logic [3:0] free_periods;
  logic [7:0] buf_data;
  logic buf_full, cec_drive_low, tx_enabled, rx_hold, irq_byte, irq_end, irq_err;
  logic [1:0] err_code;
  logic stat_byte, stat_end, stat_err, cec_in;

  int n_chk, n_fail, cyc;
  int fall_t [0:127];
  int low_w  [0:127];
  int nf, nw, hold, coll_idx;
  logic prev_drv, ack_mode, busy_low;
  logic [7:0] q_data [0:3];
  logic q_eom [0:3];
  int q_n, n_irqb, start_cyc, rel_cyc;
  logic rx_mid, saw_end, saw_err;

  cec_tx #(.CLKS_PER_TICK(CPT), .FREE_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .free_periods(free_periods),
    .broadcast(broadcast), .buf_wr(buf_wr), .buf_data(buf_data), .buf_eom(buf_eom),
    .buf_full(buf_full), .stat_clr(stat_clr), .cec_in(cec_in),
    .cec_drive_low(cec_drive_low), .tx_enabled(tx_enabled), .rx_hold(rx_hold),
    .irq_byte(irq_byte), .irq_end(irq_end), .irq_err(irq_err), .err_code(err_code),
    .stat_byte(stat_byte), .stat_end(stat_end), .stat_err(stat_err));

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cec_in = !(cec_drive_low || hold > 0 || busy_low);

  // bus monitor and partner model
  always @(negedge clk) begin
    if (hold > 0) hold <= hold - 1;
    if (cec_drive_low && !prev_drv && nf < 128) begin
      fall_t[nf] <= cyc;
      if (nf >= 1 && ack_mode && ((nf - 1) % 10) == 9) hold <= 30 * CPT;
      if (nf >= 1 && (nf - 1) == coll_idx) hold <= 30 * CPT;
      nf <= nf + 1;
    end
    if (!cec_drive_low && prev_drv && nw < 128) begin
      low_w[nw] <= cyc - fall_t[nw];
      nw <= nw + 1;
    end
    prev_drv <= cec_drive_low;
  end

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dec_byte(input int b);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[7-k] = (low_w[1 + b*10 + k] < 20 * CPT);
    return v;
  endfunction

  function automatic logic dec_bit(input int idx);
    return (low_w[idx] < 20 * CPT);
  endfunction

  task automatic run_frame(input int busy_cycles);
    int idx;
    repeat (400) @(negedge clk);
    @(posedge clk); #1;
    nf = 0; nw = 0; n_irqb = 0; saw_end = 0; saw_err = 0; rx_mid = 0;
    @(negedge clk);
    if (q_n > 0) begin
      buf_data = q_data[0]; buf_eom = q_eom[0]; buf_wr = 1'b1;
      @(negedge clk); buf_wr = 1'b0;
    end
    idx = 1;
    if (busy_cycles > 0) busy_low = 1'b1;
    tx_start = 1'b1; start_cyc = cyc;
    @(negedge clk); tx_start = 1'b0;
    if (busy_cycles > 0) begin
      repeat (busy_cycles) @(negedge clk);
      busy_low = 1'b0; rel_cyc = cyc;
    end
    for (int i = 0; i < 20000 && !saw_end && !saw_err; i++) begin
      @(negedge clk);
      buf_wr = 1'b0;
      if (i == 300 + busy_cycles) rx_mid = rx_hold;
      if (irq_byte) begin
        n_irqb++;
        if (idx < q_n) begin
          buf_data = q_data[idx]; buf_eom = q_eom[idx]; buf_wr = 1'b1; idx++;
        end
      end
      if (irq_end) saw_end = 1'b1;
      if (irq_err) saw_err = 1'b1;
    end
    @(negedge clk); buf_wr = 1'b0;
    repeat (4) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic clear_stats;
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("reset drive", !cec_drive_low, cec_drive_low, 0);
    check("reset R11 rx_hold", !rx_hold, rx_hold, 0);
    check("reset R7 enable", !tx_enabled, tx_enabled, 0);
    check("reset R5 buf/status", !buf_full && !stat_byte && !stat_end && !stat_err,
          {buf_full, stat_byte, stat_end, stat_err}, 0);
    check("reset err_code", err_code == 2'd0, err_code, 0);
  endtask

  task automatic t_single;
    q_n = 1; q_data[0] = 8'hA5; q_eom[0] = 1'b1; ack_mode = 1'b1;
    run_frame(0);
    check("R1 immediate start", (fall_t[0] - start_cyc) >= 1 && (fall_t[0] - start_cyc) <= CPT + 2,
          fall_t[0] - start_cyc, CPT);
    check("R2 start low", low_w[0] == 74 * CPT, low_w[0], 74 * CPT);
    check("R2 start total", fall_t[1] - fall_t[0] == 90 * CPT, fall_t[1] - fall_t[0], 90 * CPT);
    check("R3 bit period", fall_t[2] - fall_t[1] == BITC, fall_t[2] - fall_t[1], BITC);
    check("R3 one low", low_w[1] == 12 * CPT, low_w[1], 12 * CPT);
    check("R3 zero low", low_w[2] == 30 * CPT, low_w[2], 30 * CPT);
    check("R4 data msb first", dec_byte(0) == 8'hA5, dec_byte(0), 8'hA5);
    check("R4 eom bit", dec_bit(9) == 1'b1, dec_bit(9), 1);
    check("R4 ack pulse", low_w[10] == 12 * CPT, low_w[10], 12 * CPT);
    check("R4 edge count", nf == 11, nf, 11);
    check("R5 irq_byte count", n_irqb == 1, n_irqb, 1);
    check("R5 stat_byte", stat_byte, stat_byte, 1);
    check("R7 end seen", saw_end && !saw_err, {saw_end, saw_err}, 2);
    check("R7 stat_end", stat_end, stat_end, 1);
    check("R7 enable cleared", !tx_enabled, tx_enabled, 0);
    check("R11 rx_hold mid", rx_mid, rx_mid, 1);
    check("R11 rx_hold after", !rx_hold, rx_hold, 0);
    clear_stats();
    @(negedge clk);
    check("R7 stat_clr", !stat_byte && !stat_end, {stat_byte, stat_end}, 0);
  endtask

  task automatic t_multi;
    q_n = 3; q_data[0] = 8'h12; q_data[1] = 8'h34; q_data[2] = 8'hC3;
    q_eom[0] = 0; q_eom[1] = 0; q_eom[2] = 1; ack_mode = 1'b1;
    run_frame(0);
    check("R6 edges", nf == 31, nf, 31);
    check("R6 byte0", dec_byte(0) == 8'h12, dec_byte(0), 8'h12);
    check("R6 byte1", dec_byte(1) == 8'h34, dec_byte(1), 8'h34);
    check("R6 byte2", dec_byte(2) == 8'hC3, dec_byte(2), 8'hC3);
    check("R4 eom flags", {dec_bit(9), dec_bit(19), dec_bit(29)} == 3'b001,
          {dec_bit(9), dec_bit(19), dec_bit(29)}, 1);
    check("R3 block spacing", fall_t[11] - fall_t[10] == BITC, fall_t[11] - fall_t[10], BITC);
    check("R5 irq_byte per block", n_irqb == 3, n_irqb, 3);
    check("R7 end", saw_end && err_code == 2'd0, err_code, 0);
    clear_stats();
  endtask

  task automatic t_nack;
    q_n = 2; q_data[0] = 8'h0F; q_data[1] = 8'h01; q_eom[0] = 0; q_eom[1] = 1;
    ack_mode = 1'b0;
    run_frame(0);
    check("R8 error seen", saw_err && !saw_end, {saw_err, saw_end}, 2);
    check("R8 err_code", err_code == 2'd2, err_code, 2);
    check("R8 stops after ack", nf == 11, nf, 11);
    check("R8 released", !cec_drive_low && !tx_enabled, {cec_drive_low, tx_enabled}, 0);
    check("R8 stat_err", stat_err, stat_err, 1);
    clear_stats();
  endtask

  task automatic t_broadcast;
    broadcast = 1'b1;
    q_n = 1; q_data[0] = 8'h80; q_eom[0] = 1; ack_mode = 1'b0;
    run_frame(0);
    check("R12 high ack accepted", saw_end && err_code == 2'd0, err_code, 0);
    ack_mode = 1'b1;
    run_frame(0);
    check("R12 low ack rejected", saw_err && err_code == 2'd2, err_code, 2);
    broadcast = 1'b0;
    clear_stats();
  endtask

  task automatic t_collision;
    q_n = 1; q_data[0] = 8'hFF; q_eom[0] = 1; ack_mode = 1'b1; coll_idx = 2;
    run_frame(0);
    coll_idx = -1;
    check("R9 err_code", saw_err && err_code == 2'd3, err_code, 3);
    check("R9 no further edges", nf == 4, nf, 4);
    check("R9 released", !cec_drive_low && !rx_hold, {cec_drive_low, rx_hold}, 0);
    clear_stats();
  endtask

  task automatic t_underrun;
    q_n = 1; q_data[0] = 8'h55; q_eom[0] = 0; ack_mode = 1'b1;
    run_frame(0);
    check("R10 refill missing", saw_err && err_code == 2'd1, err_code, 1);
    check("R10 edges", nf == 11, nf, 11);
    check("R10 released", !cec_drive_low && !tx_enabled, {cec_drive_low, tx_enabled}, 0);
    q_n = 0;
    run_frame(0);
    check("R10 empty at start", saw_err && err_code == 2'd1, err_code, 1);
    check("R10 only start edge", nf == 1, nf, 1);
    clear_stats();
  endtask

  task automatic t_busy;
    q_n = 1; q_data[0] = 8'h3C; q_eom[0] = 1; ack_mode = 1'b1;
    run_frame(150);
    check("R1 no edge while busy", fall_t[0] > rel_cyc, fall_t[0], rel_cyc);
    check("R1 wait for free", (fall_t[0] - rel_cyc) >= 3 * BITC && (fall_t[0] - rel_cyc) <= 3 * BITC + 8,
          fall_t[0] - rel_cyc, 3 * BITC);
    check("R1 frame ok", saw_end && dec_byte(0) == 8'h3C, dec_byte(0), 8'h3C);
    clear_stats();
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; nf = 0; nw = 0; hold = 0; coll_idx = -1;
    prev_drv = 1'b0; ack_mode = 1'b1; busy_low = 1'b0;
    rst_n = 1'b0; tx_start = 1'b0; broadcast = 1'b0; buf_wr = 1'b0;
    buf_eom = 1'b0; buf_data = '0; stat_clr = 1'b0; free_periods = 4'd3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_nack();
    t_broadcast();
    t_collision();
    t_underrun();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule